// File: doc/BRIEF.md
# Operand-Snooping Reservation Station Bank

This block is a small pool of waiting slots for the operations bound for one class of execution unit, three slots by default. Each cycle the front end may offer one operation. The bank accepts it into the lowest-numbered idle slot and reports the tag of that slot, so that the front end can record which slot will produce the destination value. Each of the two source operands comes in one of two forms. A producer tag of zero means the supplied value is valid. A nonzero tag names the slot, in this bank or any other, that will produce the value later.

While an operand waits, its slot watches a single shared result broadcast. When the broadcast tag equals the pending tag, the slot copies the broadcast data and clears the tag. If the producer broadcasts in the same cycle that the operation is offered, the slot takes the broadcast data directly. A slot whose operands are both valid competes for the execution unit, and the lowest-numbered ready slot wins whenever the unit reports that it is idle. The slot is released when a broadcast carries its own tag, which is the moment its result is written back.

Top module: `rsb_bank`

## Requirements
- R1: After reset every slot is idle: `bank_full` is 0, `iss_tag` is 1, and `disp_valid` is 0 even with `fu_idle` high.
- R2: Slot i (counting from 0) owns the tag i+1. While `bank_full` is 0, `iss_tag` names the lowest-numbered idle slot, and an offered operation (`iss_valid`=1) is written into that slot at the clock edge.
- R3: When all slots are busy, `bank_full` is 1, `iss_tag` is 0 and an offered operation is ignored. No slot changes, so nothing new becomes dispatchable.
- R4: An operand with producer tag 0 is taken as valid. An operation offered with both tags 0 is dispatchable from the cycle after it is accepted.
- R5: A busy slot with a nonzero pending tag that matches the broadcast tag while `bc_valid` is 1 latches `bc_data` as that operand and stops waiting for it.
- R6: If an offered operand's tag matches the broadcast in the cycle of issue, the slot stores the broadcast data as a valid operand.
- R7: `disp_valid` is 1 only while `fu_idle` is 1 and some busy slot that has not yet been dispatched holds two valid operands. The `disp_op`, `disp_vj`, `disp_vk` and `disp_tag` outputs then carry that slot's contents and tag.
- R8: When several slots are ready, the slot with the lowest number is dispatched first.
- R9: A slot is dispatched once. It leaves the ready set at the edge where `disp_valid` and `fu_idle` are both 1.
- R10: A broadcast whose tag equals a busy slot's own tag frees that slot from the next cycle, which lowers `bank_full` and makes `iss_tag` point to that slot again.
- R11: A broadcast whose tag matches no pending operand and no slot's own tag changes no slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An operation is offered for issue |
| iss_op | input | 4 | Operation code of the offered operation |
| iss_qj | input | 4 | Producer tag of the first operand, 0 when the value is valid |
| iss_vj | input | 64 | First operand value |
| iss_qk | input | 4 | Producer tag of the second operand, 0 when the value is valid |
| iss_vk | input | 64 | Second operand value |
| bank_full | output | 1 | No slot is idle; issue stalls |
| iss_tag | output | 4 | Tag of the slot that would take an offered operation, 0 when full |
| bc_valid | input | 1 | A result is on the broadcast bus |
| bc_tag | input | 4 | Tag of the slot that produced the broadcast result |
| bc_data | input | 64 | Broadcast result value |
| fu_idle | input | 1 | The execution unit can take an operation this cycle |
| disp_valid | output | 1 | An operation is sent to the execution unit this cycle |
| disp_op | output | 4 | Operation code being dispatched |
| disp_vj | output | 64 | First operand being dispatched |
| disp_vk | output | 64 | Second operand being dispatched |
| disp_tag | output | 4 | Tag of the slot being dispatched |

## Verification
The assertions assume that the environment keeps the bus protocol. A slot's own tag is broadcast only after that slot has been dispatched. Each producer tag is broadcast once. No operation is offered with a pending tag that names its own destination slot. The directed stimulus keeps to these rules. It uses tags of 8 and above for producers outside the bank. It releases each slot only after its dispatch has been observed. It offers an operation while the bank is full only in the check that this offer is ignored.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    parameter int DATA_W = 64;
    parameter int TAG_W  = 4;
    parameter int OP_W   = 4;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [OP_W-1:0]   op_t;

    // one source operand: pending producer tag plus value
    typedef struct packed {
        tag_t  q;
        data_t v;
    } operand_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        data_t data;
    } bcast_t;

    typedef struct packed {
        op_t      op;
        operand_t src_j;
        operand_t src_k;
    } issue_t;

    // slot index to its fixed nonzero tag
    function automatic tag_t station_tag(int idx);
        return tag_t'(idx + 1);
    endfunction

    // a pending operand picks up the broadcast when tags agree
    function automatic operand_t snoop(operand_t cur, bcast_t bc);
        operand_t res;
        res = cur;
        if (cur.q != '0 && bc.valid && bc.tag == cur.q) begin
            res.q = '0;
            res.v = bc.data;
        end
        return res;
    endfunction

endpackage

// File: rtl/rsb_pick.sv
module rsb_pick #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);

    // lowest set bit wins
    assign gnt = req & (~req + N'(1));
    assign any = |req;

    p_gnt_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    p_gnt_in_req_r8: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

    p_gnt_present_r8: assert property (@(posedge clk) disable iff (rst)
        any |-> (gnt != '0));

    for (genvar i = 1; i < N; i++) begin : g_low
        p_lowest_first_r8: assert property (@(posedge clk) disable iff (rst)
            gnt[i] |-> (req[i-1:0] == '0));
    end

endmodule

// File: rtl/rsb_entry.sv
module rsb_entry
    import rsb_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   alloc,
    input  issue_t iss,
    input  bcast_t bc,
    input  logic   grant,
    output logic   busy_o,
    output logic   ready_o,
    output op_t    op_o,
    output data_t  vj_o,
    output data_t  vk_o
);

    localparam tag_t MY_TAG = station_tag(IDX);

    logic     busy_q;
    logic     sent_q;
    op_t      op_q;
    operand_t srcj_q;
    operand_t srck_q;

    logic     release_hit;

    assign release_hit = busy_q && bc.valid && (bc.tag == MY_TAG);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sent_q <= 1'b0;
            op_q   <= '0;
            srcj_q <= '0;
            srck_q <= '0;
        end else if (alloc) begin
            busy_q <= 1'b1;
            sent_q <= 1'b0;
            op_q   <= iss.op;
            srcj_q <= snoop(iss.src_j, bc);
            srck_q <= snoop(iss.src_k, bc);
        end else if (busy_q) begin
            srcj_q <= snoop(srcj_q, bc);
            srck_q <= snoop(srck_q, bc);
            if (grant)
                sent_q <= 1'b1;
            if (release_hit)
                busy_q <= 1'b0;
        end
    end

    assign busy_o  = busy_q;
    assign ready_o = busy_q && !sent_q && (srcj_q.q == '0) && (srck_q.q == '0);
    assign op_o    = op_q;
    assign vj_o    = srcj_q.v;
    assign vk_o    = srck_q.v;

    p_no_overwrite_r3: assert property (@(posedge clk) disable iff (rst)
        alloc |-> !busy_q);

    p_operands_valid_r7: assert property (@(posedge clk) disable iff (rst)
        grant |-> (busy_q && !sent_q && srcj_q.q == '0 && srck_q.q == '0));

    p_single_dispatch_r9: assert property (@(posedge clk) disable iff (rst)
        grant |=> !grant);

    p_capture_j_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !alloc && srcj_q.q != '0 && bc.valid && bc.tag == srcj_q.q)
        |=> (srcj_q.q == '0 && srcj_q.v == $past(bc.data)));

    p_capture_k_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !alloc && srck_q.q != '0 && bc.valid && bc.tag == srck_q.q)
        |=> (srck_q.q == '0 && srck_q.v == $past(bc.data)));

    p_bypass_j_r6: assert property (@(posedge clk) disable iff (rst)
        (alloc && iss.src_j.q != '0 && bc.valid && bc.tag == iss.src_j.q)
        |=> (srcj_q.q == '0 && srcj_q.v == $past(bc.data)));

    p_release_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_q && bc.valid && bc.tag == MY_TAG) |=> !busy_q);

endmodule

// File: rtl/rsb_bank.sv
module rsb_bank
    import rsb_pkg::*;
#(
    parameter int NUM_ST = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_qj,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [TAG_W-1:0]  iss_qk,
    input  logic [DATA_W-1:0] iss_vk,
    output logic              bank_full,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    input  logic              fu_idle,
    output logic              disp_valid,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_vj,
    output logic [DATA_W-1:0] disp_vk,
    output logic [TAG_W-1:0]  disp_tag
);

    issue_t iss;
    bcast_t bc;

    logic [NUM_ST-1:0] busy_v;
    logic [NUM_ST-1:0] ready_v;
    logic [NUM_ST-1:0] free_gnt;
    logic [NUM_ST-1:0] disp_gnt;
    logic [NUM_ST-1:0] alloc_v;
    logic [NUM_ST-1:0] disp_req;
    logic              free_any;
    logic              accept;

    op_t   op_arr [NUM_ST];
    data_t vj_arr [NUM_ST];
    data_t vk_arr [NUM_ST];

    assign iss.op      = iss_op;
    assign iss.src_j.q = iss_qj;
    assign iss.src_j.v = iss_vj;
    assign iss.src_k.q = iss_qk;
    assign iss.src_k.v = iss_vk;

    assign bc.valid = bc_valid;
    assign bc.tag   = bc_tag;
    assign bc.data  = bc_data;

    rsb_pick #(.N(NUM_ST)) u_free_pick (
        .clk (clk),
        .rst (rst),
        .req (~busy_v),
        .gnt (free_gnt),
        .any (free_any)
    );

    assign disp_req = ready_v & {NUM_ST{fu_idle}};

    rsb_pick #(.N(NUM_ST)) u_disp_pick (
        .clk (clk),
        .rst (rst),
        .req (disp_req),
        .gnt (disp_gnt),
        .any (disp_valid)
    );

    assign bank_full = !free_any;
    assign accept    = iss_valid && free_any;
    assign alloc_v   = free_gnt & {NUM_ST{accept}};

    for (genvar i = 0; i < NUM_ST; i++) begin : g_st
        rsb_entry #(.IDX(i)) u_entry (
            .clk     (clk),
            .rst     (rst),
            .alloc   (alloc_v[i]),
            .iss     (iss),
            .bc      (bc),
            .grant   (disp_gnt[i]),
            .busy_o  (busy_v[i]),
            .ready_o (ready_v[i]),
            .op_o    (op_arr[i]),
            .vj_o    (vj_arr[i]),
            .vk_o    (vk_arr[i])
        );
    end

    always_comb begin
        iss_tag = '0;
        for (int i = 0; i < NUM_ST; i++)
            if (free_gnt[i])
                iss_tag = station_tag(i);
    end

    always_comb begin
        disp_op  = '0;
        disp_vj  = '0;
        disp_vk  = '0;
        disp_tag = '0;
        for (int i = 0; i < NUM_ST; i++) begin
            if (disp_gnt[i]) begin
                disp_op  = op_arr[i];
                disp_vj  = vj_arr[i];
                disp_vk  = vk_arr[i];
                disp_tag = station_tag(i);
            end
        end
    end

    p_idle_gate_r7: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> fu_idle);

    p_full_no_tag_r3: assert property (@(posedge clk) disable iff (rst)
        bank_full |-> (iss_tag == '0));

    p_tag_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        !bank_full |-> (iss_tag != '0 && int'(iss_tag) <= NUM_ST));

    p_alloc_fills_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && $countones(busy_v) < NUM_ST)
        |=> ($countones(busy_v) >= 1));

endmodule

// File: tb/sim_rsb_bank.sv
module sim_rsb_bank;

    logic        clk = 1'b0;
    logic        rst;
    logic        iss_valid;
    logic [3:0]  iss_op;
    logic [3:0]  iss_qj;
    logic [63:0] iss_vj;
    logic [3:0]  iss_qk;
    logic [63:0] iss_vk;
    logic        bank_full;
    logic [3:0]  iss_tag;
    logic        bc_valid;
    logic [3:0]  bc_tag;
    logic [63:0] bc_data;
    logic        fu_idle;
    logic        disp_valid;
    logic [3:0]  disp_op;
    logic [63:0] disp_vj;
    logic [63:0] disp_vk;
    logic [3:0]  disp_tag;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    rsb_bank u0 (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_qj(iss_qj), .iss_vj(iss_vj), .iss_qk(iss_qk), .iss_vk(iss_vk),
        .bank_full(bank_full), .iss_tag(iss_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .fu_idle(fu_idle),
        .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_vj(disp_vj), .disp_vk(disp_vk), .disp_tag(disp_tag)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic quiet();
        iss_valid = 0; iss_op = 0; iss_qj = 0; iss_vj = 0; iss_qk = 0; iss_vk = 0;
        bc_valid = 0; bc_tag = 0; bc_data = 0;
    endtask

    task automatic issue(logic [3:0] op, logic [3:0] qj, logic [63:0] vj,
                         logic [3:0] qk, logic [63:0] vk);
        iss_valid = 1; iss_op = op; iss_qj = qj; iss_vj = vj; iss_qk = qk; iss_vk = vk;
        cyc();
        iss_valid = 0;
    endtask

    task automatic bcast(logic [3:0] tag, logic [63:0] data);
        bc_valid = 1; bc_tag = tag; bc_data = data;
        cyc();
        bc_valid = 0;
    endtask

    task automatic t_reset();
        fu_idle = 1; #1;
        check("R1 bank_full", bank_full, 0);
        check("R1 iss_tag", iss_tag, 1);
        check("R1 disp_valid", disp_valid, 0);
        fu_idle = 0;
    endtask

    task automatic t_ready_issue();
        issue(4'h3, 0, 64'hA1, 0, 64'hB2);
        #1;
        check("R2 next tag", iss_tag, 2);
        check("R7 no dispatch while busy unit", disp_valid, 0);
        fu_idle = 1; #1;
        check("R4 ready dispatch", disp_valid, 1);
        check("R7 op", disp_op, 3);
        check("R7 vj", disp_vj, 64'hA1);
        check("R7 vk", disp_vk, 64'hB2);
        check("R7 tag", disp_tag, 1);
        cyc(); #1;
        check("R9 dispatched once", disp_valid, 0);
        fu_idle = 0;
        bcast(4'd1, 64'h55); #1;
        check("R10 freed tag", iss_tag, 1);
        check("R10 not full", bank_full, 0);
    endtask

    task automatic t_snoop();
        issue(4'h5, 4'd9, 64'h0, 0, 64'h77);
        fu_idle = 1; #1;
        check("R5 waiting", disp_valid, 0);
        bcast(4'd5, 64'hDEAD); #1;
        check("R11 other tag ignored", disp_valid, 0);
        bcast(4'd9, 64'hC0FFEE); #1;
        check("R5 captured valid", disp_valid, 1);
        check("R5 captured vj", disp_vj, 64'hC0FFEE);
        check("R11 vk unchanged", disp_vk, 64'h77);
        cyc(); fu_idle = 0;
        bcast(4'd1, 64'h0);
    endtask

    task automatic t_bypass();
        bc_valid = 1; bc_tag = 4'd10; bc_data = 64'hBEEF;
        issue(4'h6, 0, 64'h12, 4'd10, 64'h0);
        bc_valid = 0;
        fu_idle = 1; #1;
        check("R6 bypass ready", disp_valid, 1);
        check("R6 bypass vk", disp_vk, 64'hBEEF);
        check("R6 bypass vj", disp_vj, 64'h12);
        cyc(); fu_idle = 0;
        bcast(4'd1, 64'h0);
    endtask

    task automatic t_full_priority();
        #1; check("R2 tag slot0", iss_tag, 1);
        issue(4'h1, 4'd11, 0, 0, 64'h100);
        #1; check("R2 tag slot1", iss_tag, 2);
        issue(4'h2, 4'd12, 0, 0, 64'h200);
        #1; check("R2 tag slot2", iss_tag, 3);
        issue(4'h3, 4'd13, 0, 0, 64'h300);
        #1;
        check("R3 full", bank_full, 1);
        check("R3 tag zero", iss_tag, 0);
        issue(4'hF, 0, 64'hBAD, 0, 64'hBAD);
        fu_idle = 1; #1;
        check("R3 ignored issue", disp_valid, 0);
        fu_idle = 0;
        bcast(4'd13, 64'h33);
        bcast(4'd11, 64'h11);
        fu_idle = 1; #1;
        check("R8 lowest first", disp_tag, 1);
        check("R8 lowest vj", disp_vj, 64'h11);
        cyc(); #1;
        check("R8 then slot2", disp_tag, 3);
        check("R8 slot2 op", disp_op, 3);
        check("R8 slot2 vj", disp_vj, 64'h33);
        cyc(); #1;
        check("R9 none left", disp_valid, 0);
        fu_idle = 0;
        bcast(4'd1, 64'h0); #1;
        check("R10 slot0 free", bank_full, 0);
        check("R10 slot0 tag", iss_tag, 1);
        bcast(4'd12, 64'h22);
        fu_idle = 1; #1;
        check("R5 slot1 dispatch", disp_tag, 2);
        check("R5 slot1 vj", disp_vj, 64'h22);
        cyc(); fu_idle = 0;
        bcast(4'd3, 64'h0);
        bcast(4'd2, 64'h0); #1;
        check("R10 all free", iss_tag, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        quiet();
        fu_idle = 0;
        rst = 1;
        repeat (3) cyc();
        rst = 0;
        t_reset();
        t_ready_issue();
        t_snoop();
        t_bypass();
        t_full_priority();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule